// File: doc/BRIEF.md
# Block-Cipher Mode Control and Handshake Register

This block is the host-facing control and status front end of a block-cipher accelerator. A host selects the chaining mode (plain codebook, CBC, CTR, CBC-MAC or CCM), the direction, the counter width and the two CCM parameters through one 32-bit control word. The block checks the selection, keeps it stable for the engine while an operation runs, and paces the traffic with four flags: context-ready, input-ready, output-ready and tag-ready. Two length words and four tag/IV readout words sit beside the control word, together with a sticky error word.

The engine side sees decoded configuration outputs and three pulses: arm (a context was accepted), block-go (the host handed over an input block) and output-taken (the host read an output block). The engine reports back with block-consumed, output-produced (with a last-block qualifier) and tag-produced, the last one carrying the 128-bit tag/IV value.

The sequencing is a six-state machine. IDLE: no operation, context-ready high. WAIT_LEN: a CCM or CBC-MAC selection was accepted and the block waits for the upper length word. RUN: blocks flow. DRAIN: the last output block waits for the host. TAG_WAIT: the engine still owes the tag/IV. TAG_RDY: the tag/IV waits for the host. Transitions: IDLE to RUN on a valid selection that needs no length; IDLE to WAIT_LEN on a valid CCM or CBC-MAC selection; WAIT_LEN to RUN on an upper length write or a valid selection needing no length; WAIT_LEN to IDLE on an invalid selection; RUN to DRAIN on the last output block; DRAIN to IDLE (save-context clear) or TAG_WAIT (set) when the host clears output-ready; TAG_WAIT to TAG_RDY on tag-produced; TAG_RDY to IDLE on a write of 1 to the tag-ready bit or a read of the fourth tag word.

Top module: `aes_mode_csr`

Word addresses: 0 control, 1 error status (bit 0), 2 lower length, 3 upper length, 4 to 7 tag/IV words (address 4 holds tag bits 31:0). Control word bits: 31 context-ready, 30 tag-ready, 29 save-context, 24:22 M, 21:19 L, 18 CCM, 15 CBC-MAC, 8:7 counter width, 6 CTR, 5 CBC, 4:3 key size, 2 direction (1 = encrypt), 1 input-ready, 0 output-ready.

## Requirements
- R1: After reset the control word reads 0x80000008 (context-ready set, key size 01, all else zero) and the error word reads 0.
- R2: Key-size bits 4:3 always read 01 and bits 28:25, 17:16 and 14:9 always read 0, whatever is written to them.
- R3: A control write accepted in IDLE with a valid selection that has neither CCM (bit 18) nor CBC-MAC (bit 15) enters RUN: input-ready reads 1, context-ready 0, and eng_arm pulses for one cycle; input-ready and context-ready are never 1 together.
- R4: A valid CCM or CBC-MAC selection leaves context-ready 1 and input-ready 0; the write to the upper length word (address 3) then arms input-ready, clears context-ready and pulses eng_arm.
- R5: A selection is invalid when CCM is set without CTR, CBC-MAC is set with direction 0, or more than one of CBC, CTR and CBC-MAC is set; it sets error bit 0 (which stays set until a write of 1 to it at address 1) and does not arm input-ready.
- R6: In RUN, a control write with bit 1 at 0 while input-ready is 1 clears it and pulses eng_blk_go; a write of 1 to bit 1 changes nothing; eng_consumed sets it again.
- R7: eng_out_valid in RUN sets output-ready; a control write with bit 0 at 0 clears it and pulses eng_out_taken; a write of 1 to bit 0 changes nothing.
- R8: An output block flagged with eng_out_last clears input-ready; when the host then clears output-ready the block returns to IDLE (context-ready 1) if save-context is 0, else waits for the tag with context-ready and tag-ready both 0.
- R9: eng_tag_valid while waiting for the tag latches the four tag words (word at address 4+i holds tag bits 32i+31:32i) and sets tag-ready; tag-ready is only 1 with save-context 1 and never together with context-ready.
- R10: Tag-ready clears on a control write with bit 30 at 1, whose other mode fields are then discarded, or on a read of address 7; a read of any other tag word leaves it set.
- R11: While context-ready is 0, control writes leave every mode field and configuration output unchanged.
- R12: The outputs decode the stored fields: cfg_ctr_bits = 32 × (width code + 1), cfg_tag_bytes = 2 × (M + 1), cfg_lenfield_bytes = L + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (only the read side effect uses it) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| eng_consumed | input | 1 | Engine took the input block |
| eng_out_valid | input | 1 | Engine produced an output block |
| eng_out_last | input | 1 | Qualifies eng_out_valid as the final block |
| eng_tag_valid | input | 1 | Engine produced the tag/IV |
| eng_tag | input | 128 | Tag/IV value, sampled with eng_tag_valid |
| eng_arm | output | 1 | One-cycle pulse when a context is armed |
| eng_blk_go | output | 1 | One-cycle pulse when the host hands over an input block |
| eng_out_taken | output | 1 | One-cycle pulse when the host reads an output block |
| cfg_dir | output | 1 | Direction, 1 = encrypt |
| cfg_cbc | output | 1 | CBC selected |
| cfg_ctr | output | 1 | CTR selected |
| cfg_mac | output | 1 | CBC-MAC selected |
| cfg_ccm | output | 1 | CCM selected |
| cfg_ctr_bits | output | 8 | Counter width in bits |
| cfg_tag_bytes | output | 5 | CCM authentication field bytes |
| cfg_lenfield_bytes | output | 4 | CCM length field bytes |
| cfg_data_len | output | 64 | Upper and lower length words |

## Verification
The checker watches on every cycle that context-ready never coincides with tag-ready or input-ready, that tag-ready only appears with save-context set, that input-ready and output-ready only rise after an arm or an engine strobe, that tag-ready only falls after a clearing write or a fourth-word read, and that the error bit is sticky. Only the bench's scenarios show the decoding of all thirty-two mode combinations into arm, wait or error, the ignored writes of 1 and of mode fields during an operation, the latched tag values and the arithmetic decode of M, L and counter width.

// File: rtl/aes_mode_pkg.sv
package aes_mode_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_LEN,
        ST_RUN,
        ST_DRAIN,
        ST_TAG_WAIT,
        ST_TAG_RDY
    } csr_state_t;

    // Control word bit positions
    localparam int B_CTX   = 31;
    localparam int B_TAGR  = 30;
    localparam int B_SAVE  = 29;
    localparam int M_LO    = 22;
    localparam int L_LO    = 19;
    localparam int B_CCM   = 18;
    localparam int B_MAC   = 15;
    localparam int W_LO    = 7;
    localparam int B_CTR   = 6;
    localparam int B_CBC   = 5;
    localparam int K_LO    = 3;
    localparam int B_DIR   = 2;
    localparam int B_IN    = 1;
    localparam int B_OUT   = 0;

    // Word addresses
    localparam int A_CTL    = 0;
    localparam int A_STAT   = 1;
    localparam int A_LEN_LO = 2;
    localparam int A_LEN_HI = 3;

    typedef struct packed {
        logic       save;
        logic [2:0] m;
        logic [2:0] l;
        logic       ccm;
        logic       mac;
        logic [1:0] ctrw;
        logic       ctr;
        logic       cbc;
        logic       dir;
    } mode_t;

    function automatic mode_t unpack_mode(input logic [31:0] w);
        mode_t r;
        r.save = w[B_SAVE];
        r.m    = w[M_LO +: 3];
        r.l    = w[L_LO +: 3];
        r.ccm  = w[B_CCM];
        r.mac  = w[B_MAC];
        r.ctrw = w[W_LO +: 2];
        r.ctr  = w[B_CTR];
        r.cbc  = w[B_CBC];
        r.dir  = w[B_DIR];
        return r;
    endfunction

endpackage

// File: rtl/aes_mode_check.sv
module aes_mode_check (
    input  logic cbc,
    input  logic ctr,
    input  logic mac,
    input  logic ccm,
    input  logic dir,
    output logic valid,
    output logic needs_len
);
    logic [1:0] n_chain;

    always_comb begin
        n_chain   = 2'(cbc) + 2'(ctr) + 2'(mac);
        valid     = !(ccm && !ctr) && !(mac && !dir) && (n_chain <= 2'd1);
        needs_len = ccm || mac;
    end
endmodule

// File: rtl/aes_tag_store.sv
module aes_tag_store #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int SEL_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [WORDS*WORD_W-1:0] tag_in,
    input  logic [SEL_W-1:0]        sel,
    output logic [WORD_W-1:0]       word
);
    logic [WORD_W-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[g] <= '0;
            else if (load)
                words[g] <= tag_in[g*WORD_W +: WORD_W];
        end
    end

    assign word = words[sel];
endmodule

// File: rtl/aes_mode_fsm.sv
module aes_mode_fsm
    import aes_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctl,
    input  logic wbit_in,
    input  logic wbit_out,
    input  logic wbit_tagr,
    input  logic accept_mode,
    input  logic mode_valid,
    input  logic mode_needs_len,
    input  logic wr_len_hi,
    input  logic rd_tag_last,
    input  logic save_ctx,
    input  logic eng_consumed,
    input  logic eng_out_valid,
    input  logic eng_out_last,
    input  logic eng_tag_valid,
    output logic ctx_rdy,
    output logic tag_rdy,
    output logic in_rdy,
    output logic out_rdy,
    output logic tag_load,
    output logic blk_go,
    output logic out_taken,
    output logic arm
);
    csr_state_t state, state_n;
    logic arm_now, clr_in, clr_out;

    assign ctx_rdy  = (state == ST_IDLE) || (state == ST_WAIT_LEN);
    assign tag_rdy  = (state == ST_TAG_RDY);
    assign tag_load = (state == ST_TAG_WAIT) && eng_tag_valid;
    assign clr_in   = wr_ctl && !wbit_in && in_rdy && (state == ST_RUN);
    assign clr_out  = wr_ctl && !wbit_out && out_rdy;
    assign arm_now  = ctx_rdy && (state_n == ST_RUN);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (accept_mode && mode_valid)
                    state_n = mode_needs_len ? ST_WAIT_LEN : ST_RUN;
            end
            ST_WAIT_LEN: begin
                if (accept_mode) begin
                    if (!mode_valid)
                        state_n = ST_IDLE;
                    else if (!mode_needs_len)
                        state_n = ST_RUN;
                end else if (wr_len_hi) begin
                    state_n = ST_RUN;
                end
            end
            ST_RUN: begin
                if (eng_out_valid && eng_out_last)
                    state_n = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (clr_out)
                    state_n = save_ctx ? ST_TAG_WAIT : ST_IDLE;
            end
            ST_TAG_WAIT: begin
                if (eng_tag_valid)
                    state_n = ST_TAG_RDY;
            end
            ST_TAG_RDY: begin
                if ((wr_ctl && wbit_tagr) || rd_tag_last)
                    state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_rdy    <= 1'b0;
            out_rdy   <= 1'b0;
            blk_go    <= 1'b0;
            out_taken <= 1'b0;
            arm       <= 1'b0;
        end else begin
            blk_go    <= clr_in;
            out_taken <= clr_out;
            arm       <= arm_now;

            if (arm_now)
                in_rdy <= 1'b1;
            else if (state_n != ST_RUN)
                in_rdy <= 1'b0;
            else if (clr_in)
                in_rdy <= 1'b0;
            else if (eng_consumed)
                in_rdy <= 1'b1;

            if ((state == ST_RUN) && eng_out_valid)
                out_rdy <= 1'b1;
            else if (clr_out)
                out_rdy <= 1'b0;
        end
    end
endmodule

// File: rtl/aes_mode_csr.sv
module aes_mode_csr
    import aes_mode_pkg::*;
#(
    parameter int  TAG_WORDS = 4,
    parameter int  LEN_W     = 32,
    localparam int ADDR_W    = $clog2(2 * TAG_WORDS),
    localparam int TAG_W     = 32 * TAG_WORDS,
    localparam int SEL_W     = $clog2(TAG_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                eng_consumed,
    input  logic                eng_out_valid,
    input  logic                eng_out_last,
    input  logic                eng_tag_valid,
    input  logic [TAG_W-1:0]    eng_tag,
    output logic                eng_arm,
    output logic                eng_blk_go,
    output logic                eng_out_taken,
    output logic                cfg_dir,
    output logic                cfg_cbc,
    output logic                cfg_ctr,
    output logic                cfg_mac,
    output logic                cfg_ccm,
    output logic [7:0]          cfg_ctr_bits,
    output logic [4:0]          cfg_tag_bytes,
    output logic [3:0]          cfg_lenfield_bytes,
    output logic [2*LEN_W-1:0]  cfg_data_len
);
    localparam int A_TAG0 = TAG_WORDS;
    localparam int A_TAGN = 2 * TAG_WORDS - 1;

    mode_t             mode_q, mode_w;
    logic [LEN_W-1:0]  len_lo_q, len_hi_q;
    logic              err_q;
    logic              wr_ctl, wr_stat, wr_len_lo, wr_len_hi, rd_tag_last;
    logic              accept_mode, mode_valid, mode_needs_len;
    logic              ctx_rdy, tag_rdy, in_rdy, out_rdy, tag_load;
    logic [31:0]       ctl_word, tag_word;

    assign mode_w      = unpack_mode(bus_wdata);
    assign wr_ctl      = bus_wr && (bus_addr == ADDR_W'(A_CTL));
    assign wr_stat     = bus_wr && (bus_addr == ADDR_W'(A_STAT));
    assign wr_len_lo   = bus_wr && (bus_addr == ADDR_W'(A_LEN_LO));
    assign wr_len_hi   = bus_wr && (bus_addr == ADDR_W'(A_LEN_HI));
    assign rd_tag_last = bus_rd && (bus_addr == ADDR_W'(A_TAGN));
    assign accept_mode = wr_ctl && ctx_rdy && !bus_wdata[B_TAGR];

    aes_mode_check check_i (
        .cbc       (mode_w.cbc),
        .ctr       (mode_w.ctr),
        .mac       (mode_w.mac),
        .ccm       (mode_w.ccm),
        .dir       (mode_w.dir),
        .valid     (mode_valid),
        .needs_len (mode_needs_len)
    );

    aes_mode_fsm fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_ctl         (wr_ctl),
        .wbit_in        (bus_wdata[B_IN]),
        .wbit_out       (bus_wdata[B_OUT]),
        .wbit_tagr      (bus_wdata[B_TAGR]),
        .accept_mode    (accept_mode),
        .mode_valid     (mode_valid),
        .mode_needs_len (mode_needs_len),
        .wr_len_hi      (wr_len_hi && ctx_rdy),
        .rd_tag_last    (rd_tag_last),
        .save_ctx       (mode_q.save),
        .eng_consumed   (eng_consumed),
        .eng_out_valid  (eng_out_valid),
        .eng_out_last   (eng_out_last),
        .eng_tag_valid  (eng_tag_valid),
        .ctx_rdy        (ctx_rdy),
        .tag_rdy        (tag_rdy),
        .in_rdy         (in_rdy),
        .out_rdy        (out_rdy),
        .tag_load       (tag_load),
        .blk_go         (eng_blk_go),
        .out_taken      (eng_out_taken),
        .arm            (eng_arm)
    );

    aes_tag_store #(.WORDS(TAG_WORDS), .WORD_W(32)) tags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tag_load),
        .tag_in (eng_tag),
        .sel    (bus_addr[SEL_W-1:0]),
        .word   (tag_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            len_lo_q <= '0;
            len_hi_q <= '0;
            err_q    <= 1'b0;
        end else begin
            if (accept_mode)
                mode_q <= mode_w;
            if (wr_len_lo && ctx_rdy)
                len_lo_q <= bus_wdata[LEN_W-1:0];
            if (wr_len_hi && ctx_rdy)
                len_hi_q <= bus_wdata[LEN_W-1:0];
            if (accept_mode && !mode_valid)
                err_q <= 1'b1;
            else if (wr_stat && bus_wdata[0])
                err_q <= 1'b0;
        end
    end

    always_comb begin
        ctl_word              = '0;
        ctl_word[B_CTX]       = ctx_rdy;
        ctl_word[B_TAGR]      = tag_rdy;
        ctl_word[B_SAVE]      = mode_q.save;
        ctl_word[M_LO +: 3]   = mode_q.m;
        ctl_word[L_LO +: 3]   = mode_q.l;
        ctl_word[B_CCM]       = mode_q.ccm;
        ctl_word[B_MAC]       = mode_q.mac;
        ctl_word[W_LO +: 2]   = mode_q.ctrw;
        ctl_word[B_CTR]       = mode_q.ctr;
        ctl_word[B_CBC]       = mode_q.cbc;
        ctl_word[K_LO +: 2]   = 2'b01;
        ctl_word[B_DIR]       = mode_q.dir;
        ctl_word[B_IN]        = in_rdy;
        ctl_word[B_OUT]       = out_rdy;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr >= ADDR_W'(A_TAG0))
            bus_rdata = tag_word;
        else if (bus_addr == ADDR_W'(A_CTL))
            bus_rdata = ctl_word;
        else if (bus_addr == ADDR_W'(A_STAT))
            bus_rdata = {31'b0, err_q};
        else if (bus_addr == ADDR_W'(A_LEN_LO))
            bus_rdata = 32'(len_lo_q);
        else
            bus_rdata = 32'(len_hi_q);
    end

    assign cfg_dir            = mode_q.dir;
    assign cfg_cbc            = mode_q.cbc;
    assign cfg_ctr            = mode_q.ctr;
    assign cfg_mac            = mode_q.mac;
    assign cfg_ccm            = mode_q.ccm;
    assign cfg_ctr_bits       = {3'(mode_q.ctrw) + 3'd1, 5'b0};
    assign cfg_tag_bytes      = {4'(mode_q.m) + 4'd1, 1'b0};
    assign cfg_lenfield_bytes = 4'(mode_q.l) + 4'd1;
    assign cfg_data_len       = {len_hi_q, len_lo_q};
endmodule

// File: rtl/aes_mode_csr_chk.sv
module aes_mode_csr_chk
    import aes_mode_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              eng_consumed,
    input logic              eng_out_valid,
    input logic              eng_arm,
    input logic              eng_blk_go,
    input logic              ctx_rdy,
    input logic              tag_rdy,
    input logic              in_rdy,
    input logic              out_rdy,
    input logic              err,
    input logic              save_ctx
);
    localparam logic [ADDR_W-1:0] LAST_TAG = {ADDR_W{1'b1}};

    assert_ctx_in_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctx_rdy && in_rdy));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(bus_wr && bus_addr == ADDR_W'(A_STAT) && bus_wdata[0])) |=> err);

    assert_in_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_rdy) |-> (eng_arm || $past(eng_consumed)));

    assert_blk_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_blk_go |-> (!in_rdy && $past(in_rdy)));

    assert_out_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_rdy) |-> $past(eng_out_valid));

    assert_tag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctx_rdy && tag_rdy));

    assert_tag_needs_save_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tag_rdy |-> save_ctx);

    assert_tag_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tag_rdy) |-> $past((bus_wr && bus_addr == ADDR_W'(A_CTL) && bus_wdata[B_TAGR])
                                 || (bus_rd && bus_addr == LAST_TAG)));
endmodule

bind aes_mode_csr aes_mode_csr_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .eng_consumed  (eng_consumed),
    .eng_out_valid (eng_out_valid),
    .eng_arm       (eng_arm),
    .eng_blk_go    (eng_blk_go),
    .ctx_rdy       (ctx_rdy),
    .tag_rdy       (tag_rdy),
    .in_rdy        (in_rdy),
    .out_rdy       (out_rdy),
    .err           (err_q),
    .save_ctx      (mode_q.save)
);

// File: tb/aes_mode_csr_tb.sv
`timescale 1ns/1ps
module aes_mode_csr_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0, bus_rdata;
    logic         eng_consumed = 1'b0, eng_out_valid = 1'b0, eng_out_last = 1'b0, eng_tag_valid = 1'b0;
    logic [127:0] eng_tag = '0;
    logic         eng_arm, eng_blk_go, eng_out_taken;
    logic         cfg_dir, cfg_cbc, cfg_ctr, cfg_mac, cfg_ccm;
    logic [7:0]   cfg_ctr_bits;
    logic [4:0]   cfg_tag_bytes;
    logic [3:0]   cfg_lenfield_bytes;
    logic [63:0]  cfg_data_len;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    aes_mode_csr dut_i (.*);

    localparam logic [31:0] CTX = 32'h8000_0000, TAGR = 32'h4000_0000, SAVE = 32'h2000_0000;
    localparam logic [31:0] CCM = 32'h0004_0000, MAC = 32'h0000_8000, CTR = 32'h0000_0040;
    localparam logic [31:0] CBC = 32'h0000_0020, DIR = 32'h0000_0004, KEY = 32'h0000_0008;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input int a, output logic [31:0] d);
        bus_addr = a[2:0];
        #0.5;
        d = bus_rdata;
    endtask

    task automatic rd_fx(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a[2:0];
        #0.5;
        d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // 0 consumed, 1 output, 2 last output, 3 tag
    task automatic eng(input int which);
        @(negedge clk);
        eng_consumed  = (which == 0);
        eng_out_valid = (which == 1) || (which == 2);
        eng_out_last  = (which == 2);
        eng_tag_valid = (which == 3);
        @(posedge clk);
        @(negedge clk);
        eng_consumed = 0; eng_out_valid = 0; eng_out_last = 0; eng_tag_valid = 0;
    endtask

    task automatic flags(output logic [3:0] f);
        logic [31:0] w;
        peek(0, w);
        f = {w[31], w[30], w[1], w[0]};   // ctx, tag, in, out
    endtask

    task automatic finish_op(input bit save);
        logic [3:0] f;
        eng(2);
        flags(f);
        chk("R8 last block", {28'b0, f}, 32'h1);
        wr(0, 32'h2);
        flags(f);
        chk("R8 drain exit", {28'b0, f}, save ? 32'h0 : 32'h8);
    endtask

    initial begin
        logic [31:0] w;
        logic [3:0]  f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        peek(0, w); chk("R1 control reset", w, CTX | KEY);
        peek(1, w); chk("R1 error reset", w, 0);

        // R2: reserved bits and key size; CCM+CTR waits for length
        wr(0, CCM | CTR | 32'h1E03_7E18);
        peek(0, w); chk("R2 reserved/key readback", w, CTX | CCM | CTR | KEY);

        // R12: sweep M, L, width while waiting for length
        for (int m = 0; m < 8; m++)
            for (int l = 0; l < 8; l++)
                for (int cw = 0; cw < 4; cw++) begin
                    wr(0, CCM | CTR | DIR | (32'(m) << 22) | (32'(l) << 19) | (32'(cw) << 7));
                    chk("R12 ctr bits", 32'(cfg_ctr_bits), 32'(32 * (cw + 1)));
                    chk("R12 tag bytes", 32'(cfg_tag_bytes), 32'(2 * (m + 1)));
                    chk("R12 len field", 32'(cfg_lenfield_bytes), 32'(l + 1));
                end

        // R4: length words arm the context
        wr(2, 32'h1234_5678);
        flags(f); chk("R4 low length no arm", {28'b0, f}, 32'h8);
        wr(3, 32'h0000_00AB);
        chk("R4 arm pulse", 32'(eng_arm), 1);
        flags(f); chk("R4 armed flags", {28'b0, f}, 32'h2);
        chk("R4 length out", cfg_data_len[63:32] ^ cfg_data_len[31:0], 32'h1234_56D3);

        // R11: mode writes ignored during an operation
        wr(0, CBC | 32'h3);
        chk("R11 ccm kept", {30'b0, cfg_ccm, cfg_cbc}, 32'h2);
        chk("R11 tag bytes kept", 32'(cfg_tag_bytes), 16);

        // R6: input handshake
        wr(0, 32'h1);
        chk("R6 blk_go pulse", 32'(eng_blk_go), 1);
        flags(f); chk("R6 in cleared", {28'b0, f}, 32'h0);
        wr(0, 32'h3);
        flags(f); chk("R6 write 1 ignored", {28'b0, f}, 32'h0);
        eng(0);
        flags(f); chk("R6 consumed rearm", {28'b0, f}, 32'h2);

        // R7: output handshake
        eng(1);
        flags(f); chk("R7 out set", {28'b0, f}, 32'h3);
        wr(0, 32'h3);
        chk("R7 no taken", 32'(eng_out_taken), 0);
        flags(f); chk("R7 write 1 ignored", {28'b0, f}, 32'h3);
        wr(0, 32'h2);
        chk("R7 taken pulse", 32'(eng_out_taken), 1);
        flags(f); chk("R7 out cleared", {28'b0, f}, 32'h2);
        finish_op(0);

        // R3 / R4 / R5: every combination of cbc, ctr, mac, ccm, dir
        for (int c = 0; c < 32; c++) begin
            bit cb, ct, mc, cc, dr, bad, nl;
            cb = c[0]; ct = c[1]; mc = c[2]; cc = c[3]; dr = c[4];
            bad = (cc && !ct) || (mc && !dr) || ((int'(cb) + int'(ct) + int'(mc)) > 1);
            nl  = cc || mc;
            wr(0, (cb ? CBC : 0) | (ct ? CTR : 0) | (mc ? MAC : 0) | (cc ? CCM : 0) | (dr ? DIR : 0));
            if (bad) begin
                peek(1, w); chk("R5 error set", w, 1);
                flags(f); chk("R5 no arm", {28'b0, f}, 32'h8);
                wr(0, 0 | CBC | DIR | SAVE | TAGR);
                peek(1, w); chk("R5 error sticky", w, 1);
                wr(1, 1);
                peek(1, w); chk("R5 error cleared", w, 0);
            end else if (nl) begin
                flags(f); chk("R4 waits for length", {28'b0, f}, 32'h8);
                wr(3, 32'(c));
                chk("R4 arm on length", 32'(eng_arm), 1);
                flags(f); chk("R4 armed", {28'b0, f}, 32'h2);
                finish_op(0);
            end else begin
                chk("R3 arm pulse", 32'(eng_arm), 1);
                flags(f); chk("R3 armed", {28'b0, f}, 32'h2);
                finish_op(0);
            end
        end

        // R9 / R10: tag path, cleared by reading the fourth word
        eng_tag = 128'hDDDD_0004_CCCC_0003_BBBB_0002_AAAA_0001;
        wr(0, CBC | DIR | SAVE);
        finish_op(1);
        eng(3);
        flags(f); chk("R9 tag ready", {28'b0, f}, 32'h4);
        peek(0, w); chk("R9 save bit", 32'(w[29]), 1);
        for (int i = 0; i < 3; i++) begin
            rd_fx(4 + i, w);
            chk("R9 tag word", w, eng_tag[32*i +: 32]);
            flags(f); chk("R10 early read keeps tag", {28'b0, f}, 32'h4);
        end
        rd_fx(7, w); chk("R9 tag word 3", w, 32'hDDDD_0004);
        flags(f); chk("R10 read clears", {28'b0, f}, 32'h8);

        // R10: cleared by write of bit 30, other fields discarded
        wr(0, CBC | DIR | SAVE);
        finish_op(1);
        eng(3);
        wr(0, TAGR | CTR | 32'h3);
        flags(f); chk("R10 write clears", {28'b0, f}, 32'h8);
        peek(0, w); chk("R10 fields discarded", w & (CBC | CTR), CBC);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule